// File: doc/BRIEF.md
# Texture Texel Fetch Pipeline

This block turns a stream of integer texel coordinates into byte addresses within a linearly stored texture. For each coordinate it issues one read to an external texture memory, then returns the 32-bit word that comes back, with a valid strobe. The strobe is delayed to match the memory's fixed read latency. A coordinate can be presented on every clock and there is no backpressure, so a rasterizer can feed it at full rate and get colors back in the order it sent the coordinates.

The texture layout is described by a byte base address, a row pitch given in units of 64 texels, and a storage-format code. Only the 32-bit-per-texel linear format (code 0x00) is decoded. For any other code the block still issues the read and still raises valid, but it returns zero as the color.

Top module: `tex_fetch_pipe`

## Requirements
- R1: In every cycle where `in_vld` is 1, `rd_en` is 1 in that same cycle, with the address for that cycle's coordinate. `rd_en` is 0 in every cycle where `in_vld` is 0.
- R2: `rd_addr` = (`tex_base` + (`tv` * `pitch64` * 64 + `tu`) * 4) mod 2^32. Byte offsets run from the base, and the memory selects 32-bit words by `rd_addr >> 2`.
- R3: The address arithmetic is done at a width that cannot overflow. This holds even at the largest values (`tu` = `tv` = 2047, `pitch64` = 16383); the only truncation is the final one to 32 bits.
- R4: `out_vld` is 1 exactly `RD_LAT` cycles after the cycle in which the matching read was issued (default `RD_LAT` = 1). No output appears that has no matching read.
- R5: When the format code was 0x00, `out_color` equals the 32-bit word present on `rd_data` in the cycle `out_vld` is 1, unmodified.
- R6: Coordinates on consecutive cycles produce outputs on consecutive cycles, in input order.
- R7: While `rst` (synchronous, active high) is 1, and until new reads complete after it falls, `out_vld` stays 0. This holds even if `in_vld` was 1 during reset.
- R8: For any format code other than 0x00, the read is still issued and `out_vld` still rises, but `out_color` is 0.
- R9: `out_color` is 0 in every cycle where `out_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Coordinate valid |
| tu | input | 11 | Texel column |
| tv | input | 11 | Texel row |
| tex_base | input | 32 | Texture byte base address |
| pitch64 | input | 14 | Row pitch in units of 64 texels |
| fmt | input | 6 | Storage-format code (0x00 = 32-bit linear) |
| rd_en | output | 1 | Memory read request |
| rd_addr | output | 32 | Memory byte address |
| rd_data | input | 32 | Memory read word, valid `RD_LAT` cycles after the request |
| out_vld | output | 1 | Color valid |
| out_color | output | 32 | Fetched texel color |

## Verification
The bench drives the largest coordinate and pitch values together. A design whose row product or index sum is held in too few bits would give a wrong address there, even though small coordinates come out correct. It runs an unbroken stream of reads with the memory latency set above one, alongside streams with gaps. An off-by-one in the valid delay would pair each color with a neighbouring coordinate, and a shortened delay line would lose strobes. It also sets odd base addresses and a zero pitch to catch a design that aligns the base or ignores the pitch. It sends unsupported format codes mixed in with good ones to catch a design that drops their strobe, leaks memory data through, or applies the zeroing to the wrong item in flight. Finally, it holds `in_vld` high during reset to catch a valid pipeline that reset does not clear.

// File: rtl/tex_fetch_pkg.sv
package tex_fetch_pkg;

  typedef enum logic [5:0] {
    FMT_RGBA32_LINEAR = 6'h00
  } tex_fmt_e;

  localparam int ROW_UNIT_LOG2    = 6;   // pitch counts rows in units of 64 texels
  localparam int TEXEL_BYTES_LOG2 = 2;   // 4 bytes per 32-bit texel

  function automatic logic fmt_is_supported(input logic [5:0] code);
    return code == FMT_RGBA32_LINEAR;
  endfunction

endpackage

// File: rtl/tex_addr_calc.sv
module tex_addr_calc
  import tex_fetch_pkg::*;
#(
  parameter int COORD_W = 11,
  parameter int PITCH_W = 14,
  parameter int ADDR_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req,
  input  logic [COORD_W-1:0] tu,
  input  logic [COORD_W-1:0] tv,
  input  logic [ADDR_W-1:0]  base,
  input  logic [PITCH_W-1:0] pitch64,
  input  logic [5:0]         fmt,
  output logic [ADDR_W-1:0]  addr,
  output logic               fmt_ok
);

  // Wide enough for v*pitch*64 + u, scaled to bytes, plus the base.
  localparam int PROD_W = COORD_W + PITCH_W + ROW_UNIT_LOG2;
  localparam int IDX_W  = PROD_W + 1;
  localparam int OFF_W  = IDX_W + TEXEL_BYTES_LOG2;
  localparam int SUM_W  = ((OFF_W > ADDR_W) ? OFF_W : ADDR_W) + 1;

  logic [PROD_W-1:0] row_texels;
  logic [IDX_W-1:0]  texel_idx;
  logic [OFF_W-1:0]  byte_off;
  logic [SUM_W-1:0]  byte_addr;

  always_comb begin
    row_texels = PROD_W'(tv) * PROD_W'(pitch64);
    row_texels = row_texels << ROW_UNIT_LOG2;
    texel_idx  = IDX_W'(row_texels) + IDX_W'(tu);
    byte_off   = OFF_W'(texel_idx) << TEXEL_BYTES_LOG2;
    byte_addr  = SUM_W'(base) + SUM_W'(byte_off);
  end

  assign addr   = byte_addr[ADDR_W-1:0];
  assign fmt_ok = fmt_is_supported(fmt);

  // R2: word alignment of the address follows the base's low bits
  a_r2_base_alignment: assert property (@(posedge clk) disable iff (rst)
    req |-> addr[TEXEL_BYTES_LOG2-1:0] == base[TEXEL_BYTES_LOG2-1:0]);

  // R2: one column step moves the address by one texel
  a_r2_column_step: assert property (@(posedge clk) disable iff (rst)
    (req && $past(req) && !$past(rst) && tv == $past(tv) && base == $past(base) &&
     pitch64 == $past(pitch64) && tu == $past(tu) + 1'b1)
    |-> addr == $past(addr) + ADDR_W'(1 << TEXEL_BYTES_LOG2));

endmodule

// File: rtl/tex_lat_line.sv
module tex_lat_line #(
  parameter int RD_LAT = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic issue,
  input  logic fmt_ok,
  output logic done,
  output logic done_ok
);

  localparam int CNT_W = $clog2(RD_LAT + 2);

  logic [RD_LAT-1:0] vld_sr;
  logic [RD_LAT-1:0] ok_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_sr[0] <= 1'b0;
      ok_sr[0]  <= 1'b0;
    end else begin
      vld_sr[0] <= issue;
      ok_sr[0]  <= issue & fmt_ok;
    end
  end

  for (genvar s = 1; s < RD_LAT; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        vld_sr[s] <= 1'b0;
        ok_sr[s]  <= 1'b0;
      end else begin
        vld_sr[s] <= vld_sr[s-1];
        ok_sr[s]  <= ok_sr[s-1];
      end
    end
  end

  assign done    = vld_sr[RD_LAT-1];
  assign done_ok = ok_sr[RD_LAT-1];

  // Checker: reads in flight can never exceed the latency depth
  logic [CNT_W-1:0] inflight;
  always_ff @(posedge clk) begin
    if (rst) inflight <= '0;
    else     inflight <= inflight + CNT_W'(issue) - CNT_W'(done);
  end

  // R4: no completion without an outstanding read
  a_r4_no_orphan_done: assert property (@(posedge clk) disable iff (rst)
    done |-> inflight != '0);

  // R6: full-rate issue never piles up beyond the pipeline depth
  a_r6_inflight_bound: assert property (@(posedge clk) disable iff (rst)
    inflight <= CNT_W'(RD_LAT));

  // R8: a good-format mark only travels with a valid
  a_r8_ok_implies_done: assert property (@(posedge clk) disable iff (rst)
    done_ok |-> done);

endmodule

// File: rtl/tex_color_out.sv
module tex_color_out #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  logic              done_ok,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] color
);

  always_comb begin
    color = '0;
    if (done && done_ok) color = rd_data;
  end

  // R9: idle cycles carry no color
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !done |-> color == '0);

  // R5: a good-format result passes memory data through
  a_r5_passthrough: assert property (@(posedge clk) disable iff (rst)
    (done && done_ok) |-> color == rd_data);

endmodule

// File: rtl/tex_fetch_pipe.sv
module tex_fetch_pipe
  import tex_fetch_pkg::*;
#(
  parameter int COORD_W = 11,
  parameter int PITCH_W = 14,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int RD_LAT  = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_vld,
  input  logic [COORD_W-1:0] tu,
  input  logic [COORD_W-1:0] tv,
  input  logic [ADDR_W-1:0]  tex_base,
  input  logic [PITCH_W-1:0] pitch64,
  input  logic [5:0]         fmt,
  output logic               rd_en,
  output logic [ADDR_W-1:0]  rd_addr,
  input  logic [DATA_W-1:0]  rd_data,
  output logic               out_vld,
  output logic [DATA_W-1:0]  out_color
);

  logic fmt_ok;
  logic done;
  logic done_ok;

  tex_addr_calc #(
    .COORD_W(COORD_W), .PITCH_W(PITCH_W), .ADDR_W(ADDR_W)
  ) u_addr (
    .clk(clk), .rst(rst), .req(in_vld),
    .tu(tu), .tv(tv), .base(tex_base), .pitch64(pitch64), .fmt(fmt),
    .addr(rd_addr), .fmt_ok(fmt_ok)
  );

  assign rd_en = in_vld;

  tex_lat_line #(.RD_LAT(RD_LAT)) u_lat (
    .clk(clk), .rst(rst), .issue(rd_en), .fmt_ok(fmt_ok),
    .done(done), .done_ok(done_ok)
  );

  tex_color_out #(.DATA_W(DATA_W)) u_color (
    .clk(clk), .rst(rst), .done(done), .done_ok(done_ok),
    .rd_data(rd_data), .color(out_color)
  );

  assign out_vld = done;

  // R7: the cycle after reset shows no output valid
  a_r7_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_vld);

endmodule

// File: tb/tex_fetch_pipe_bench.sv
`timescale 1ns/1ps
module tex_fetch_pipe_bench;

  localparam int RD_LAT = 2;
  localparam int HALF   = 10;   // 50 MHz

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_vld = 1'b0;
  logic [10:0] tu = '0, tv = '0;
  logic [31:0] tex_base = '0;
  logic [13:0] pitch64 = '0;
  logic [5:0]  fmt = '0;
  logic        rd_en;
  logic [31:0] rd_addr;
  logic [31:0] rd_data;
  logic        out_vld;
  logic [31:0] out_color;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #HALF clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tex_fetch_pipe #(.RD_LAT(RD_LAT)) u_tex_fetch_pipe (
    .clk(clk), .rst(rst), .in_vld(in_vld), .tu(tu), .tv(tv),
    .tex_base(tex_base), .pitch64(pitch64), .fmt(fmt),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .out_vld(out_vld), .out_color(out_color)
  );

  // Memory model: word content is a function of the word index (addr >> 2)
  function automatic logic [31:0] word_at(input logic [31:0] a);
    logic [31:0] idx;
    idx = a >> 2;
    return (idx * 32'h9E3779B1) ^ 32'h5A5AC3C3;
  endfunction

  logic [31:0] dpipe [RD_LAT];
  always @(posedge clk) begin
    dpipe[0] <= rd_en ? word_at(rd_addr) : 32'hBAD0BAD0;
    for (int k = 1; k < RD_LAT; k++) dpipe[k] <= dpipe[k-1];
  end
  assign rd_data = dpipe[RD_LAT-1];

  function automatic logic [31:0] exp_addr(input logic [10:0] u, input logic [10:0] v,
                                           input logic [31:0] b, input logic [13:0] p);
    logic [63:0] t;
    t = 64'(b) + (64'(v) * 64'(p) * 64'd64 + 64'(u)) * 64'd4;
    return t[31:0];
  endfunction

  typedef struct { logic [31:0] color; int due; string tag; } exp_t;
  exp_t sb[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%08h expected=%08h", req, what, act, expv);
    end
  endtask

  // Driver: one coordinate per call, on the following cycle
  task automatic issue(input logic [10:0] u, input logic [10:0] v, input logic [31:0] b,
                       input logic [13:0] p, input logic [5:0] f, input string tag);
    logic [31:0] a;
    exp_t e;
    @(negedge clk);
    in_vld = 1'b1; tu = u; tv = v; tex_base = b; pitch64 = p; fmt = f;
    #1;
    a = exp_addr(u, v, b, p);
    check(rd_en === 1'b1, "R1", "rd_en with input", 32'(rd_en), 32'd1);
    check(rd_addr === a, tag, "rd_addr", rd_addr, a);
    e.color = (f == 6'h00) ? word_at(a) : 32'h0;
    e.due   = cyc + RD_LAT;
    e.tag   = (f == 6'h00) ? "R5" : "R8";
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_vld = 1'b0;
      #1;
      check(rd_en === 1'b0, "R1", "rd_en while idle", 32'(rd_en), 32'd0);
    end
  endtask

  // Monitor: compare each produced result with the head of the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (out_vld === 1'b1) begin
        if (sb.size() == 0) begin
          check(1'b0, "R4", "valid with no read outstanding", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(cyc == e.due, "R4", "result cycle", 32'(cyc), 32'(e.due));
          check(out_color === e.color, e.tag, "out_color", out_color, e.color);
        end
      end else begin
        check(out_color === 32'h0, "R9", "color while not valid", out_color, 32'h0);
        if (sb.size() != 0 && sb[0].due <= cyc)
          check(1'b0, "R6", "expected result missing", 32'd0, 32'd1);
      end
    end
  end

  initial begin
    // R7: valid inputs during reset must not leak out
    @(negedge clk);
    in_vld = 1'b1; tu = 11'd7; tv = 11'd3; pitch64 = 14'd1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(out_vld === 1'b0, "R7", "out_vld during reset", 32'(out_vld), 32'd0);
    end
    in_vld = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < RD_LAT + 2; i++) begin
      @(negedge clk);
      check(out_vld === 1'b0, "R7", "out_vld after reset", 32'(out_vld), 32'd0);
    end

    // R2: basic coordinates with a gap between each
    issue(11'd3, 11'd2, 32'h0, 14'd1, 6'h00, "R2");
    idle(2);
    issue(11'd0, 11'd0, 32'h0, 14'd1, 6'h00, "R2");
    idle(1);
    issue(11'd5, 11'd1, 32'h0000_1003, 14'd2, 6'h00, "R2");
    idle(3);

    // R2: zero pitch means rows collapse onto the base row
    issue(11'd9, 11'd500, 32'h0000_0040, 14'd0, 6'h00, "R2");
    idle(2);

    // R3: largest coordinate and pitch, base near the top of memory
    issue(11'd2047, 11'd2047, 32'hFFFF_FF00, 14'd16383, 6'h00, "R3");
    issue(11'd2047, 11'd2047, 32'h0, 14'd16383, 6'h00, "R3");
    issue(11'd0, 11'd2047, 32'h1234_5677, 14'd16383, 6'h00, "R3");
    idle(3);

    // R6: unbroken stream, varying coordinates
    for (int i = 0; i < 24; i++)
      issue(11'(i * 37), 11'(i * 5 + 1), 32'h0000_2000 + 32'(i), 14'(i % 4 + 1), 6'h00, "R6");
    idle(RD_LAT + 2);

    // R8: unsupported formats interleaved with good ones at full rate
    issue(11'd4, 11'd4, 32'h100, 14'd1, 6'h01, "R8");
    issue(11'd5, 11'd4, 32'h100, 14'd1, 6'h00, "R8");
    issue(11'd6, 11'd4, 32'h100, 14'd1, 6'h3F, "R8");
    issue(11'd7, 11'd4, 32'h100, 14'd1, 6'h02, "R8");
    issue(11'd8, 11'd4, 32'h100, 14'd1, 6'h00, "R8");
    idle(RD_LAT + 3);

    check(sb.size() == 0, "R4", "results outstanding at end", 32'(sb.size()), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R4 watchdog expired actual=%08h expected=%08h", 32'd1, 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule